// File: doc/BRIEF.md
# Sleep Entry and Interrupt Wake-up Controller

This controller sits beside a small processor core and governs power-down. When the core executes its sleep instruction it raises `sleep_req` for one cycle. The controller first looks for any interrupt source whose enable and flag are both set. If one is found, the sleep is treated as a no-operation and the core keeps running. If none is found, the sleep is committed: the watchdog clear strobes pulse, the time-out and power-down status bits are updated, and the core is halted.

While the core is asleep, any enabled flag wakes it, even when global interrupts are off. Unless the part runs from an external clock, the oscillator is stopped during sleep. On wake it must be counted through a start-up wait of `OST_LEN` oscillator ticks before the core resumes. The global enable is sampled at the moment of wake. If it is set, one dummy cycle is inserted and a vector request sends the core to its handler. If it is clear, the core simply resumes at the instruction after the sleep.

The state machine has four states. RUN is normal execution. ASLEEP means halted with the oscillator stopped. OSTWAIT means halted while the start-up wait is counted. DUMMY is the single filler cycle ahead of the handler.

The transitions are:
- RUN→ASLEEP on a committed sleep.
- ASLEEP→OSTWAIT on wake, when not in external-clock mode.
- ASLEEP→DUMMY on wake in external-clock mode with the global enable set.
- ASLEEP→RUN on wake in external-clock mode with the global enable clear.
- OSTWAIT→DUMMY when the wait completes and the sampled enable is set.
- OSTWAIT→RUN when the wait completes and the sampled enable is clear.
- DUMMY→RUN always.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A wake condition is any source with `irq_en[i]` and `irq_flag[i]` both 1; it wakes the block from sleep whatever the value of `gie`; while asleep, flags without enables keep the block asleep.
- R2: If a wake condition is present in the cycle `sleep_req` is sampled in RUN, the sleep is a no-operation: `core_halt` stays 0, no clear strobe pulses, and `to_bit`/`pd_bit` keep their values.
- R3: A committed sleep (no wake condition when `sleep_req` is sampled) gives, in the next cycle, `core_halt`=1, one-cycle pulses on `wdt_clr` and `wdt_scale_clr`, `to_bit`=1 and `pd_bit`=0.
- R4: If `gie` is 1 at wake, `dummy_cycle` is 1 for exactly one cycle and is followed by one cycle with both `vec_req` and `resume` at 1. If `gie` is 0, `resume` pulses with `vec_req`=0 and no dummy cycle occurs.
- R5: Outside external-clock mode, after wake `osc_wait` and `core_halt` stay 1 until exactly `OST_LEN` cycles with `osc_tick`=1 have been seen (default 1024); only ticks advance the count.
- R6: With `ext_clk_mode`=1 the start-up wait is skipped: `osc_wait` never rises, and the cycle after wake is either DUMMY or the resume cycle.
- R7: `osc_run` is 0 while asleep unless `ext_clk_mode`=1; it is 1 in every other state.
- R8: After reset: `to_bit`=1, `pd_bit`=1, `core_halt`=0, `osc_run`=1, and every strobe is 0.
- R9: `sleep_req` has no effect unless the block is in RUN: a request during sleep or start-up pulses no strobe and does not change the wait length.
- R10: `resume`, `vec_req`, `wdt_clr` and `wdt_scale_clr` are each single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sleep_req | input | 1 | One-cycle pulse: sleep instruction executing |
| irq_flag | input | N_SRC | Per-source interrupt flags |
| irq_en | input | N_SRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| ext_clk_mode | input | 1 | 1 = external clock, no start-up wait |
| osc_tick | input | 1 | One oscillator period elapsed |
| core_halt | output | 1 | Core stalled (asleep or start-up wait) |
| osc_run | output | 1 | Oscillator enable |
| osc_wait | output | 1 | Start-up wait in progress |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| wdt_scale_clr | output | 1 | Watchdog prescaler/postscaler clear pulse |
| to_bit | output | 1 | Time-out status bit |
| pd_bit | output | 1 | Power-down status bit |
| dummy_cycle | output | 1 | Filler cycle before the handler |
| vec_req | output | 1 | Pulse: redirect core to the handler at 0004h |
| resume | output | 1 | Pulse: core execution resumes |

## Verification
The assertions assume that `sleep_req` is a single-cycle pulse. They also assume that flag, enable and `gie` change only between clock edges, so the wake condition and the global enable sampled at each edge are the ones driven. The stimulus drives every input on the falling edge. It raises `sleep_req` for exactly one cycle, and it clears the flags once `resume` is seen, before the next sleep. The stimulus also uses tick patterns with gaps, so the start-up count is exercised on ticks rather than on cycles.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_ASLEEP  = 2'd1,
        ST_OSTWAIT = 2'd2,
        ST_DUMMY   = 2'd3
    } slp_state_e;

endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] irq_flag,
    input  logic [N_SRC-1:0] irq_en,
    output logic             wake
);
    logic [N_SRC-1:0] armed;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_src
            assign armed[gi] = irq_flag[gi] & irq_en[gi];
        end
    endgenerate

    // Global enable deliberately plays no part here: wake ignores it.
    assign wake = |armed;
endmodule

// File: rtl/slp_ost_timer.sv
module slp_ost_timer #(
    parameter int OST_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick,
    output logic done
);
    localparam int CW = (OST_LEN > 2) ? $clog2(OST_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run_en && tick && (cnt_q == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                        // R5
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> (cnt_q == '0));                     // R5
endmodule

// File: rtl/slp_status.sv
module slp_status (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    output logic to_bit,
    output logic pd_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_bit <= 1'b1;
            pd_bit <= 1'b1;
        end else if (commit) begin
            to_bit <= 1'b1;
            pd_bit <= 1'b0;
        end
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slp_pkg::*;
#(
    parameter int N_SRC   = 8,
    parameter int OST_LEN = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [N_SRC-1:0] irq_flag,
    input  logic [N_SRC-1:0] irq_en,
    input  logic             gie,
    input  logic             ext_clk_mode,
    input  logic             osc_tick,
    output logic             core_halt,
    output logic             osc_run,
    output logic             osc_wait,
    output logic             wdt_clr,
    output logic             wdt_scale_clr,
    output logic             to_bit,
    output logic             pd_bit,
    output logic             dummy_cycle,
    output logic             vec_req,
    output logic             resume
);
    slp_state_e state_q, state_d;
    logic       gie_lat_q, gie_lat_d;
    logic       wake;
    logic       ost_done;
    logic       commit;

    slp_wake_detect #(.N_SRC(N_SRC)) u_wake (
        .irq_flag (irq_flag),
        .irq_en   (irq_en),
        .wake     (wake)
    );

    slp_ost_timer #(.OST_LEN(OST_LEN)) u_ost (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (state_q == ST_OSTWAIT),
        .tick   (osc_tick),
        .done   (ost_done)
    );

    // Sleep is committed only when no enabled flag is pending at the request.
    assign commit = (state_q == ST_RUN) && sleep_req && !wake;

    slp_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .to_bit (to_bit),
        .pd_bit (pd_bit)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        gie_lat_d = gie_lat_q;
        unique case (state_q)
            ST_RUN: begin
                if (commit) state_d = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (wake) begin
                    gie_lat_d = gie;
                    if (ext_clk_mode) state_d = gie ? ST_DUMMY : ST_RUN;
                    else              state_d = ST_OSTWAIT;
                end
            end
            ST_OSTWAIT: begin
                if (ost_done) state_d = gie_lat_q ? ST_DUMMY : ST_RUN;
            end
            ST_DUMMY: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            gie_lat_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            gie_lat_q <= gie_lat_d;
        end
    end

    // Outputs: registered strobes, level outputs decoded from the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_clr       <= 1'b0;
            wdt_scale_clr <= 1'b0;
            resume        <= 1'b0;
            vec_req       <= 1'b0;
        end else begin
            wdt_clr       <= commit;
            wdt_scale_clr <= commit;
            resume        <= (state_q != ST_RUN) && (state_d == ST_RUN);
            vec_req       <= (state_q == ST_DUMMY);
        end
    end

    assign core_halt   = (state_q == ST_ASLEEP) || (state_q == ST_OSTWAIT);
    assign osc_wait    = (state_q == ST_OSTWAIT);
    assign dummy_cycle = (state_q == ST_DUMMY);
    assign osc_run     = ext_clk_mode || (state_q != ST_ASLEEP);

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && wake) |=>
            (!core_halt && !wdt_clr && $stable(pd_bit) && $stable(to_bit)));   // R2
    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && !wake) |=>
            (core_halt && wdt_clr && wdt_scale_clr && to_bit && !pd_bit));      // R3
    AST_ASLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && !wake) |=> (state_q == ST_ASLEEP));           // R1
    AST_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && !ext_clk_mode) |-> !osc_run);                 // R7
    AST_EC_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && ext_clk_mode) |=> !osc_wait);                 // R6
    AST_VEC_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (resume && $past(dummy_cycle)));                           // R4
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);                                                 // R10
    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);                                                   // R10
    AST_NO_CLR_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> !wdt_clr);                                     // R9
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
    localparam int N_SRC   = 8;
    localparam int OST_LEN = 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic [N_SRC-1:0] irq_flag = '0;
    logic [N_SRC-1:0] irq_en = '0;
    logic             gie = 1'b0;
    logic             ext_clk_mode = 1'b0;
    logic             osc_tick = 1'b1;
    logic core_halt, osc_run, osc_wait, wdt_clr, wdt_scale_clr;
    logic to_bit, pd_bit, dummy_cycle, vec_req, resume;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sleep_wake_ctrl #(.N_SRC(N_SRC), .OST_LEN(OST_LEN)) i_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_flag(irq_flag),
        .irq_en(irq_en), .gie(gie), .ext_clk_mode(ext_clk_mode), .osc_tick(osc_tick),
        .core_halt(core_halt), .osc_run(osc_run), .osc_wait(osc_wait),
        .wdt_clr(wdt_clr), .wdt_scale_clr(wdt_scale_clr), .to_bit(to_bit),
        .pd_bit(pd_bit), .dummy_cycle(dummy_cycle), .vec_req(vec_req), .resume(resume)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ck(input int act, input int exp);
        return (act == exp) ? 1 : 0;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // Commit a sleep and check the entry cycle.
    task automatic enter_sleep(input string tag);
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk(ck(core_halt, 1), {tag, " R3 halt"}, core_halt, 1);
        chk(ck(wdt_clr, 1) && ck(wdt_scale_clr, 1), {tag, " R3 clr"}, wdt_clr, 1);
        chk(ck(to_bit, 1) && ck(pd_bit, 0), {tag, " R3 pd"}, pd_bit, 0);
        chk(ck(osc_run, int'(ext_clk_mode)), {tag, " R7 osc_run"}, osc_run, int'(ext_clk_mode));
        step();
        chk(ck(wdt_clr, 0) && ck(wdt_scale_clr, 0), {tag, " R10 clr single"}, wdt_clr, 0);
    endtask

    // Count ticks through the start-up wait; optional gappy ticks and a stray request.
    task automatic run_ost(input bit gappy, input bit stray, input string tag);
        int n = 0;
        int k = 0;
        chk(ck(osc_wait, 1) && ck(core_halt, 1), {tag, " R5 wait"}, osc_wait, 1);
        while (osc_wait && k < 10000) begin
            osc_tick = gappy ? ((k % 3) == 0) : 1'b1;
            if (osc_tick) n++;
            sleep_req = (stray && k == 5);
            k++;
            step();
            if (stray && k == 6)
                chk(ck(wdt_clr, 0), {tag, " R9 stray req"}, wdt_clr, 0);
        end
        sleep_req = 1'b0;
        osc_tick = 1'b1;
        chk(ck(n, OST_LEN), {tag, " R5 tick count"}, n, OST_LEN);
    endtask

    // Check the resume sequence; first observation is the cycle after leaving wait/sleep.
    task automatic check_resume(input bit g, input string tag);
        if (g) begin
            chk(ck(dummy_cycle, 1) && ck(resume, 0), {tag, " R4 dummy"}, dummy_cycle, 1);
            step();
            chk(ck(dummy_cycle, 0), {tag, " R4 dummy one"}, dummy_cycle, 0);
            chk(ck(vec_req, 1) && ck(resume, 1) && ck(core_halt, 0), {tag, " R4 vector"}, vec_req, 1);
        end else begin
            chk(ck(resume, 1) && ck(vec_req, 0) && ck(dummy_cycle, 0), {tag, " R4 inline"}, resume, 1);
        end
        irq_flag = '0;
        step();
        chk(ck(resume, 0) && ck(vec_req, 0), {tag, " R10 resume single"}, resume, 0);
    endtask

    task automatic t_reset();
        chk(ck(to_bit, 1) && ck(pd_bit, 1), "R8 status", pd_bit, 1);
        chk(ck(core_halt, 0) && ck(osc_run, 1), "R8 run", core_halt, 0);
        chk(ck(wdt_clr | resume | vec_req | dummy_cycle | osc_wait, 0), "R8 strobes", wdt_clr, 0);
    endtask

    task automatic t_nop();
        irq_en = 8'h10; irq_flag = 8'h10; gie = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk(ck(core_halt, 0), "R2 nop no halt", core_halt, 0);
        chk(ck(wdt_clr | wdt_scale_clr, 0), "R2 nop no clr", wdt_clr, 0);
        chk(ck(pd_bit, 1) && ck(to_bit, 1), "R2 nop status", pd_bit, 1);
        irq_flag = '0;
        step();
    endtask

    task automatic t_sleep(input bit ec, input bit g, input bit gappy, input bit stray, input string tag);
        ext_clk_mode = ec;
        gie = g;
        irq_en = 8'h03;
        irq_flag = '0;
        enter_sleep(tag);
        irq_flag = 8'h80;               // flag without enable must not wake
        step(); step();
        chk(ck(core_halt, 1) && ck(osc_wait, 0), {tag, " R1 unarmed"}, core_halt, 1);
        irq_flag = 8'h82;               // bit1 armed
        step();
        if (ec) begin
            chk(ck(osc_wait, 0), {tag, " R6 no wait"}, osc_wait, 0);
        end else begin
            run_ost(gappy, stray, tag);
        end
        check_resume(g, tag);
        ext_clk_mode = 1'b0;
    endtask

    task automatic t_nop_after_sleep();
        irq_en = 8'h01; irq_flag = 8'h01;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk(ck(pd_bit, 0) && ck(core_halt, 0), "R2 nop keeps pd=0", pd_bit, 0);
        irq_flag = '0;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_nop();
        t_sleep(1'b0, 1'b0, 1'b0, 1'b0, "osc inline R1");
        t_sleep(1'b0, 1'b1, 1'b1, 1'b1, "osc vector gappy");
        t_sleep(1'b1, 1'b1, 1'b0, 1'b0, "ec vector R6");
        t_sleep(1'b1, 1'b0, 1'b0, 1'b0, "ec inline R6");
        t_nop_after_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule